// File: doc/BRIEF.md
# Crosspoint Routing Configuration Target

This block is the control side of a 12-input, 9-output video routing matrix. It listens on a two-wire serial bus (I2C, open-drain SCL and SDA), with both lines sampled by the system clock. It accepts write transfers only, and from them it holds the state that steers the analog fabric. For each output that state is an enable, a two-bit gain code and a one-hot input select. For the inputs it is a clamp/bias mode vector.

A controller sends a START, then the device byte, then a register pointer, then any number of data bytes. The pointer advances after each data byte, so a single transfer can fill several registers in a row. The device byte is decided by a strap pin. A device byte that does not match is left unacknowledged, and the target stays silent until the next START. Writes to register addresses that hold nothing are still acknowledged but change nothing.

The bus engine is one state machine with the states IDLE, GET_DEV, ACK_DEV, GET_PTR, ACK_PTR, GET_DATA, ACK_DATA and SKIP. Its transitions are:
- START from any state goes to GET_DEV.
- STOP from any state goes to IDLE.
- GET_DEV goes to ACK_DEV after eight bits that match the device byte, and to SKIP after eight bits that do not.
- ACK_DEV goes to GET_PTR when the ninth clock falls.
- GET_PTR goes to ACK_PTR after eight bits.
- ACK_PTR goes to GET_DATA when the ninth clock falls.
- GET_DATA goes to ACK_DATA after eight bits, and the register write is issued on that step.
- ACK_DATA goes back to GET_DATA when the ninth clock falls, and the pointer advances on that step.

Top module: `xbar_cfg_top`

## Requirements
- R1: While reset is asserted and right after it, every output enable, gain code, select bit and clamp bit is 0, and SDA is not pulled.
- R2: The target answers to device byte 0x06 when `addr_sel_i` is 0 and to 0x86 when it is 1. It acknowledges the device byte, the pointer byte and every data byte of a matching transfer by pulling SDA low for the whole high phase of the ninth clock.
- R3: A device byte that does not match is not acknowledged, including 0x07 and 0x87 with the read bit set. The bytes that follow it are neither acknowledged nor written until the next START, and a repeated START is honoured.
- R4: The byte after the device byte sets the register pointer. Each data byte is written to the pointer's register, and the pointer then increments by one, wrapping at 8 bits.
- R5: Registers 0x01 to 0x09 belong to outputs 0 to 8. Bit 7 drives `out_en_o[k]`. Bits 6:5 drive `out_gain_o[2k+1:2k]`. When the output is enabled, a select code c in bits 4:0 with 1 ≤ c ≤ 12 drives only bit `out_sel_o[12k+c-1]`.
- R6: When bit 7 of an output register is 0, all 12 select bits of that output are 0, whatever bits 4:0 hold.
- R7: Select code 0 and codes 13 to 31 give all-zero select bits for that output.
- R8: In register 0x1D, bit i sets `clamp_mode_o[i]` for i = 0..7. In register 0x1E, bits 3:0 set `clamp_mode_o[11:8]`, and its bits 7:4 have no effect. A 1 selects clamp and a 0 selects bias.
- R9: Writes to register 0x00, 0x0A to 0x1C, or 0x1F to 0xFF are acknowledged and change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_sel_i | input | 1 | Strap that picks the device byte (0: 0x06, 1: 0x86) |
| sda_oe_o | output | 1 | When 1, SDA is pulled low; SDA is never driven high |
| out_en_o | output | 9 | Per-output enable |
| out_gain_o | output | 18 | Per-output gain code, 2 bits each (00 = 6 dB up to 11 = 9 dB) |
| out_sel_o | output | 108 | Per-output one-hot input select, 12 bits each |
| clamp_mode_o | output | 12 | Per-input mode, 1 = clamp and 0 = bias |

## Verification
The hardest state to reach is the SKIP state while a later byte on the bus would otherwise write a live register. The target must stay mute through the ninth clock of each of those bytes and then recover on a repeated START that comes without a STOP. The bench reaches it by sending a wrong device byte, a read device byte, or a byte with the strap flipped, each followed by pointer and data bytes aimed at output registers. It then issues a fresh START straight from the low-clock phase of a transfer that was not acknowledged. Random transfers mix these mismatches with bursts that cross the register map edges, so the pointer also runs into undefined addresses mid-burst.

// File: rtl/xcfg_pkg.sv
package xcfg_pkg;
    localparam int          XB_OUTPUTS    = 9;
    localparam int          XB_INPUTS     = 12;
    localparam int          SEL_W         = 5;
    localparam int          GAIN_W        = 2;
    localparam logic [7:0]  OUT_REG_BASE  = 8'h01;
    localparam logic [7:0]  CLAMP_REG_LO  = 8'h1D;
    localparam logic [7:0]  CLAMP_REG_HI  = 8'h1E;
    localparam logic [6:0]  DEV_LOW_BITS  = 7'h06;

    typedef enum logic [2:0] {
        S_IDLE,
        S_GET_DEV,
        S_ACK_DEV,
        S_GET_PTR,
        S_ACK_PTR,
        S_GET_DATA,
        S_ACK_DATA,
        S_SKIP
    } tgt_state_t;
endpackage

// File: rtl/xcfg_line_sync.sv
module xcfg_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_m, sda_m, scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_m <= 1'b1;
            sda_m <= 1'b1;
            scl_s <= 1'b1;
            sda_s <= 1'b1;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_m <= scl_i;
            sda_m <= sda_i;
            scl_s <= scl_m;
            sda_s <= sda_m;
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/xcfg_i2c_target.sv
module xcfg_i2c_target
    import xcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic       addr_sel,
    output logic       sda_oe,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data
);
    tgt_state_t state_q, state_d;
    logic [7:0] shift_q;
    logic [3:0] bits_q;
    logic [7:0] ptr_q;
    logic       byte_done;
    logic [7:0] dev_byte;
    logic       is_rx;
    logic       ack_next;

    assign byte_done = scl_fall && (bits_q == 4'd8);
    assign dev_byte  = {addr_sel, DEV_LOW_BITS};
    assign is_rx     = (state_q == S_GET_DEV) || (state_q == S_GET_PTR) ||
                       (state_q == S_GET_DATA);
    assign ack_next  = (state_d == S_ACK_DEV) || (state_d == S_ACK_PTR) ||
                       (state_d == S_ACK_DATA);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = S_GET_DEV;
        end else if (stop_det) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE:     state_d = S_IDLE;
                S_GET_DEV:  if (byte_done) state_d = (shift_q == dev_byte) ? S_ACK_DEV : S_SKIP;
                S_ACK_DEV:  if (scl_fall)  state_d = S_GET_PTR;
                S_GET_PTR:  if (byte_done) state_d = S_ACK_PTR;
                S_ACK_PTR:  if (scl_fall)  state_d = S_GET_DATA;
                S_GET_DATA: if (byte_done) state_d = S_ACK_DATA;
                S_ACK_DATA: if (scl_fall)  state_d = S_GET_DATA;
                S_SKIP:     state_d = S_SKIP;
                default:    state_d = S_IDLE;
            endcase
        end
    end

    // state register and receive datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            shift_q <= '0;
            bits_q  <= '0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != state_d) begin
                bits_q <= '0;
            end else if (is_rx && scl_rise) begin
                shift_q <= {shift_q[6:0], sda_s};
                bits_q  <= bits_q + 4'd1;
            end
            if (state_q == S_GET_PTR && byte_done && !start_det && !stop_det)
                ptr_q <= shift_q;
            else if (state_q == S_ACK_DATA && state_d == S_GET_DATA)
                ptr_q <= ptr_q + 8'd1;
        end
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            sda_oe  <= ack_next;
            wr_en   <= (state_q == S_GET_DATA) && (state_d == S_ACK_DATA);
            wr_addr <= ptr_q;
            wr_data <= shift_q;
        end
    end
endmodule

// File: rtl/xcfg_reg_bank.sv
module xcfg_reg_bank
    import xcfg_pkg::*;
#(
    parameter int N_OUT = XB_OUTPUTS,
    parameter int N_IN  = XB_INPUTS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [7:0]              wr_addr,
    input  logic [7:0]              wr_data,
    output logic [N_OUT-1:0]        out_en,
    output logic [GAIN_W*N_OUT-1:0] out_gain,
    output logic [N_OUT*N_IN-1:0]   out_sel,
    output logic [N_IN-1:0]         clamp_mode
);
    localparam int HI_W = N_IN - 8;

    logic [7:0]      clamp_lo_q;
    logic [HI_W-1:0] clamp_hi_q;

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        logic [7:0] ctrl_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ctrl_q <= '0;
            else if (wr_en && wr_addr == OUT_REG_BASE + 8'(k))
                ctrl_q <= wr_data;
        end
        assign out_en[k] = ctrl_q[7];
        assign out_gain[GAIN_W*k +: GAIN_W] = ctrl_q[6:5];
        for (genvar j = 0; j < N_IN; j++) begin : g_sel
            assign out_sel[k*N_IN + j] = ctrl_q[7] && (ctrl_q[SEL_W-1:0] == SEL_W'(j + 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clamp_lo_q <= '0;
            clamp_hi_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == CLAMP_REG_LO) clamp_lo_q <= wr_data;
            if (wr_addr == CLAMP_REG_HI) clamp_hi_q <= wr_data[HI_W-1:0];
        end
    end

    assign clamp_mode = {clamp_hi_q, clamp_lo_q};
endmodule

// File: rtl/xbar_cfg_top.sv
module xbar_cfg_top
    import xcfg_pkg::*;
#(
    parameter int N_OUT = XB_OUTPUTS,
    parameter int N_IN  = XB_INPUTS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    input  logic                    addr_sel_i,
    output logic                    sda_oe_o,
    output logic [N_OUT-1:0]        out_en_o,
    output logic [GAIN_W*N_OUT-1:0] out_gain_o,
    output logic [N_OUT*N_IN-1:0]   out_sel_o,
    output logic [N_IN-1:0]         clamp_mode_o
);
    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       wr_en;
    logic [7:0] wr_addr, wr_data;

    xcfg_line_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    xcfg_i2c_target u_tgt (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .addr_sel  (addr_sel_i),
        .sda_oe    (sda_oe_o),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    xcfg_reg_bank #(.N_OUT(N_OUT), .N_IN(N_IN)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .out_en     (out_en_o),
        .out_gain   (out_gain_o),
        .out_sel    (out_sel_o),
        .clamp_mode (clamp_mode_o)
    );
endmodule

// File: rtl/xcfg_checker.sv
module xcfg_checker #(
    parameter int N_OUT = 9,
    parameter int N_IN  = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   scl_s,
    input logic                   sda_oe,
    input logic                   wr_en,
    input logic [N_OUT-1:0]       out_en,
    input logic [2*N_OUT-1:0]     out_gain,
    input logic [N_OUT*N_IN-1:0]  out_sel,
    input logic [N_IN-1:0]        clamp
);
    // R1: reset clears the routing state and releases SDA
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (out_en == '0 && clamp == '0 && !sda_oe));

    // R2: the acknowledge pull only starts or ends while SCL is low
    assert_ack_edge_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_s);

    // R4: visible state moves only after a write strobe
    assert_hold_without_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({out_en, out_gain, clamp}));

    for (genvar k = 0; k < N_OUT; k++) begin : g_chk
        // R5: at most one input per output
        assert_one_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(out_sel[k*N_IN +: N_IN]));
        // R6: a disabled output routes nothing
        assert_off_unrouted_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !out_en[k] |-> (out_sel[k*N_IN +: N_IN] == '0));
    end
endmodule

bind xbar_cfg_top xcfg_checker #(.N_OUT(N_OUT), .N_IN(N_IN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_oe   (sda_oe_o),
    .wr_en    (wr_en),
    .out_en   (out_en_o),
    .out_gain (out_gain_o),
    .out_sel  (out_sel_o),
    .clamp    (clamp_mode_o)
);

// File: tb/xbar_cfg_top_tb.sv
module xbar_cfg_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 6;
    localparam int NO         = 9;
    localparam int NI         = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic addr_sel = 1'b0;
    logic sda_oe;
    logic [NO-1:0]    out_en;
    logic [2*NO-1:0]  out_gain;
    logic [NO*NI-1:0] out_sel;
    logic [NI-1:0]    clamp;
    wire  sda_line = m_sda & ~sda_oe;

    int checks = 0;
    int fails  = 0;

    logic [7:0] m_ctrl [NO];
    logic [7:0] m_clo;
    logic [3:0] m_chi;
    logic [7:0] tx_data [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    xbar_cfg_top dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (m_scl),
        .sda_i        (sda_line),
        .addr_sel_i   (addr_sel),
        .sda_oe_o     (sda_oe),
        .out_en_o     (out_en),
        .out_gain_o   (out_gain),
        .out_sel_o    (out_sel),
        .clamp_mode_o (clamp)
    );

    task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    function automatic void model_reset();
        for (int k = 0; k < NO; k++) m_ctrl[k] = 8'h00;
        m_clo = 8'h00;
        m_chi = 4'h0;
    endfunction

    function automatic void model_write(input logic [7:0] a, input logic [7:0] d);
        if (a >= 8'h01 && a <= 8'h09) m_ctrl[a - 8'h01] = d;
        else if (a == 8'h1D) m_clo = d;
        else if (a == 8'h1E) m_chi = d[3:0];
    endfunction

    function automatic logic [NO-1:0] exp_en();
        logic [NO-1:0] v;
        for (int k = 0; k < NO; k++) v[k] = m_ctrl[k][7];
        return v;
    endfunction

    function automatic logic [2*NO-1:0] exp_gain();
        logic [2*NO-1:0] v;
        for (int k = 0; k < NO; k++) v[2*k +: 2] = m_ctrl[k][6:5];
        return v;
    endfunction

    function automatic logic [NO*NI-1:0] exp_sel();
        logic [NO*NI-1:0] v;
        int c;
        v = '0;
        for (int k = 0; k < NO; k++) begin
            c = int'(m_ctrl[k][4:0]);
            if (m_ctrl[k][7] && c >= 1 && c <= NI) v[k*NI + c - 1] = 1'b1;
        end
        return v;
    endfunction

    task automatic check_outputs(input string tag);
        check({tag, " enable R5"}, 128'(out_en), 128'(exp_en()));
        check({tag, " gain R5"}, 128'(out_gain), 128'(exp_gain()));
        check({tag, " select R5/R6/R7"}, 128'(out_sel), 128'(exp_sel()));
        check({tag, " clamp R8"}, 128'(clamp), 128'({m_chi, m_clo}));
    endtask

    task automatic wait_h();
        repeat (H) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; wait_h();
        m_scl = 1'b1; wait_h();
        m_sda = 1'b0; wait_h();
        m_scl = 1'b0; wait_h();
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; wait_h();
        m_scl = 1'b1; wait_h();
        m_sda = 1'b1; wait_h();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s1, s2;
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wait_h();
            m_scl = 1'b1; wait_h();
            m_scl = 1'b0; wait_h();
        end
        m_sda = 1'b1; wait_h();
        m_scl = 1'b1;
        @(negedge clk);
        s1 = sda_line;
        repeat (H - 2) @(negedge clk);
        s2 = sda_line;
        @(negedge clk);
        m_scl = 1'b0; wait_h();
        acked = !s1 && !s2;
    endtask

    task automatic xfer(input logic [7:0] dev, input logic [7:0] ptr, input int len,
                        input logic do_stop, input string tag);
        logic ack, match;
        logic [17:0] got_a, exp_a;
        logic [7:0] p;
        match = (dev == {addr_sel, 7'h06});
        got_a = '0;
        exp_a = '0;
        i2c_start();
        send_byte(dev, ack); got_a[0] = ack; exp_a[0] = match;
        send_byte(ptr, ack); got_a[1] = ack; exp_a[1] = match;
        p = ptr;
        for (int i = 0; i < len; i++) begin
            send_byte(tx_data[i], ack);
            got_a[i+2] = ack;
            exp_a[i+2] = match;
            if (match) model_write(p, tx_data[i]);
            p = p + 8'd1;
        end
        if (do_stop) i2c_stop();
        check({tag, " ack pattern R2/R3"}, 128'(got_a), 128'(exp_a));
        check_outputs(tag);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R4 got=timeout exp=completion");
        finish_run();
    end

    initial begin
        int seed_dummy;
        seed_dummy = int'($urandom(32'h1357_9bdf));
        model_reset();
        repeat (5) @(negedge clk);
        check("reset sda_oe R1", 128'(sda_oe), 128'(0));
        check_outputs("reset R1");
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R5: enabled, gain 11, input 12
        tx_data[0] = 8'hEC;
        xfer(8'h06, 8'h01, 1, 1'b1, "R5 out0 in12");
        // R6: disabled with a live code
        tx_data[0] = 8'h05;
        xfer(8'h06, 8'h02, 1, 1'b1, "R6 disabled");
        // R7: code 0, code 13 and code 31
        tx_data[0] = 8'h80; tx_data[1] = 8'hAD; tx_data[2] = 8'h9F;
        xfer(8'h06, 8'h03, 3, 1'b1, "R7 off codes");
        // R4: burst across all output registers
        for (int i = 0; i < NO; i++) tx_data[i] = {1'b1, 2'(i % 4), 5'(i + 1)};
        xfer(8'h06, 8'h01, NO, 1'b1, "R4 burst");
        // R8: clamp registers, reserved bits set
        tx_data[0] = 8'hA5; tx_data[1] = 8'hFF;
        xfer(8'h06, 8'h1D, 2, 1'b1, "R8 clamp");
        tx_data[0] = 8'h3C; tx_data[1] = 8'hF6;
        xfer(8'h06, 8'h1D, 2, 1'b1, "R8 clamp reserved");
        // R9: undefined addresses
        tx_data[0] = 8'hFF;
        xfer(8'h06, 8'h00, 1, 1'b1, "R9 addr 00");
        tx_data[0] = 8'h81; tx_data[1] = 8'h82; tx_data[2] = 8'h83;
        xfer(8'h06, 8'h0A, 3, 1'b1, "R9 addr 0A-0C");
        tx_data[0] = 8'h11; tx_data[1] = 8'h22;
        xfer(8'h06, 8'h1F, 2, 1'b1, "R9 addr 1F-20");
        tx_data[0] = 8'h81;
        xfer(8'h06, 8'hFF, 1, 1'b1, "R9 addr FF");
        // R2: strap high
        addr_sel = 1'b1;
        tx_data[0] = 8'hC3;
        xfer(8'h86, 8'h04, 1, 1'b1, "R2 strap high");
        // R3: wrong strap, read bit
        tx_data[0] = 8'h00;
        xfer(8'h06, 8'h04, 1, 1'b1, "R3 strap mismatch");
        xfer(8'h87, 8'h04, 1, 1'b1, "R3 read bit");
        addr_sel = 1'b0;
        xfer(8'h07, 8'h01, 1, 1'b1, "R3 read bit low strap");
        // R3: skipped transfer, then a repeated START without STOP
        tx_data[0] = 8'h00;
        xfer(8'h46, 8'h01, 1, 1'b0, "R3 skip no stop");
        tx_data[0] = 8'h8B;
        xfer(8'h06, 8'h09, 1, 1'b1, "R3 repeated start");

        // random transfers mixed with the directed ones
        for (int t = 0; t < 40; t++) begin
            int r, n;
            logic [7:0] dev, ptr;
            addr_sel = 1'($urandom % 2);
            r = int'($urandom % 10);
            if (r < 7)       dev = {addr_sel, 7'h06};
            else if (r == 7) dev = {~addr_sel, 7'h06};
            else if (r == 8) dev = {addr_sel, 7'h07};
            else             dev = 8'($urandom);
            r = int'($urandom % 4);
            if (r < 2)       ptr = 8'(1 + $urandom % 9);
            else if (r == 2) ptr = 8'(8'h1C + $urandom % 3);
            else             ptr = 8'($urandom);
            n = 1 + int'($urandom % 3);
            for (int i = 0; i < n; i++) tx_data[i] = 8'($urandom);
            xfer(dev, ptr, n, 1'b1, "random R4/R5/R6/R7");
        end

        // R1: reset in mid-run clears everything
        rst_n = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        check("mid-run reset sda_oe R1", 128'(sda_oe), 128'(0));
        check_outputs("mid-run reset R1");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_outputs("after reset release R1");
        finish_run();
    end
endmodule